// File: doc/BRIEF.md
# I2C Block-Write Configuration Register Target

This block is an I2C target that receives block writes into a small bank of 8-bit configuration registers. A frame opens with a start condition and the write address byte `0xD2`. That byte is the 7-bit device address `0x69` with the direction bit at 0. Two header bytes follow: first the index of the first register to write, then the number of data bytes. After them come the data bytes, which land in consecutive registers starting at that index. The host ends the frame with a stop.

The block runs on a system clock. It samples SCL and SDA, which must already be synchronized to that clock. It answers each byte by asserting a pull-down enable for SDA during the acknowledge clock. The whole register bank is presented as one flat parallel output, with register `i` on bits `[8*i+7:8*i]`.

It has no read path and never stretches the clock. The open-drain pad is outside the block.

Top module: `i2c_blkwr_slave`

## Requirements
- R1: On a clock edge with `rst_n` low, every register takes the value `RST_VAL` and `sda_pull` goes to 0.
- R2: When the 8 address bits shifted in MSB first equal `0xD2`, `sda_pull` is 1 through the whole ninth SCL clock of that byte.
- R3: Any other address byte, including `0xD3` (read bit set), gets no acknowledge. The block then ignores all bytes, acknowledging none and writing none, until the next start.
- R4: After an accepted address, the first byte sets the starting register index M and the second sets the byte count N. Both are acknowledged.
- R5: Data byte k (k counting from 0) is written to register M+k and acknowledged, provided k < N and M+k < NREG.
- R6: Once N data bytes have been taken, a further data byte is neither acknowledged nor written, and neither is any byte after it.
- R7: A data byte aimed at a register index of NREG or above is neither acknowledged nor written, and neither is any byte after it.
- R8: A stop, or a repeated start, at any bit position ends the frame. Registers already written keep their values. After a repeated start the next frame is decoded normally.
- R9: `sda_pull` changes only while SCL is low. A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl | input | 1 | Synchronized bus clock level |
| sda | input | 1 | Synchronized bus data level |
| sda_pull | output | 1 | 1 = drive SDA low (acknowledge) |
| regs_o | output | 8*NREG | Register bank, register i at bits [8*i+7:8*i] |

## Verification
A bit counter that slips, or a shift register that is off by one, shows up on the ninth clock of the address byte. There the acknowledge is either missing or lands one clock early or late, so the fault appears at the first byte of the first frame. A wrong index or a wrong remaining-count register does not stall the bus. It shows as a register holding the wrong value, or as an acknowledge that differs from the model on a byte at the edge of the count or of the bank. The bench therefore compares every acknowledge bit and the whole bank after every frame.

// File: rtl/i2c_blkwr_slave.sv
module i2c_blkwr_slave #(
  parameter int          NREG     = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter logic [7:0]  RST_VAL  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              sda,
  output logic              sda_pull,
  output logic [NREG*8-1:0] regs_o
);
  localparam int         AW     = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [8:0] NREG_W = 9'(NREG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_BEGIN, S_COUNT, S_DATA} st_t;

  st_t        state;
  logic       scl_q, sda_q;
  logic [3:0] bitcnt;
  logic [7:0] sh, idx, left;
  logic [7:0] bank [NREG];

  wire start_c   = scl & scl_q & sda_q & ~sda;
  wire stop_c    = scl & scl_q & ~sda_q & sda;
  wire scl_rise  = scl & ~scl_q;
  wire scl_fall  = ~scl & scl_q;
  wire byte_done = scl_fall && (bitcnt == 4'd8);
  wire ack_done  = scl_fall && (bitcnt == 4'd9);
  wire addr_hit  = (sh == {DEV_ADDR, 1'b0});
  wire data_ok   = (left != 8'd0) && ({1'b0, idx} < NREG_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      bitcnt   <= 4'd0;
      sh       <= 8'd0;
      idx      <= 8'd0;
      left     <= 8'd0;
      sda_pull <= 1'b0;
      for (int i = 0; i < NREG; i++) bank[i] <= RST_VAL;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (start_c) begin
        state    <= S_ADDR;
        bitcnt   <= 4'd0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        state    <= S_IDLE;
        sda_pull <= 1'b0;
      end else if (state != S_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) sh <= {sh[6:0], sda};
          bitcnt <= bitcnt + 4'd1;
        end
        if (byte_done) begin
          sda_pull <= 1'b1;
          case (state)
            S_ADDR:
              if (addr_hit) state <= S_BEGIN;
              else begin
                sda_pull <= 1'b0;
                state    <= S_IDLE;
              end
            S_BEGIN: begin
              idx   <= sh;
              state <= S_COUNT;
            end
            S_COUNT: begin
              left  <= sh;
              state <= S_DATA;
            end
            S_DATA:
              if (data_ok) begin
                bank[idx[AW-1:0]] <= sh;
                idx  <= idx + 8'd1;
                left <= left - 8'd1;
              end else begin
                sda_pull <= 1'b0;
                state    <= S_IDLE;
              end
            default: state <= S_IDLE;
          endcase
        end
        if (ack_done) begin
          sda_pull <= 1'b0;
          bitcnt   <= 4'd0;
        end
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*8 +: 8] = bank[g];
  end
endmodule

// File: rtl/i2c_blkwr_chk.sv
module i2c_blkwr_chk #(
  parameter int         NREG    = 8,
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl,
  input logic              sda,
  input logic              sda_pull,
  input logic [NREG*8-1:0] regs_o
);
  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (regs_o == {NREG{RST_VAL}} && !sda_pull));

  p_ack_in_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl);

  p_pull_steady_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && $past(scl)) |-> $stable(sda_pull));

  p_write_in_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(regs_o) && $past(rst_n)) |-> !scl);

  p_stop_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && $past(scl) && !$past(sda) && sda) |-> !sda_pull);
endmodule

bind i2c_blkwr_slave i2c_blkwr_chk #(.NREG(NREG), .RST_VAL(RST_VAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda),
  .sda_pull(sda_pull), .regs_o(regs_o)
);

// File: tb/tb_i2c_blkwr_slave.sv
module tb_i2c_blkwr_slave;
  localparam int         NREG = 8;
  localparam logic [7:0] RSTV = 8'hA5;
  localparam int         Q    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_host = 1'b1;
  logic sda_pull;
  logic [NREG*8-1:0] regs_o;
  wire  sda_bus = sda_host & ~sda_pull;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [7:0] exp_r [NREG];

  always #2.5 clk = ~clk;

  i2c_blkwr_slave #(.NREG(NREG), .DEV_ADDR(7'h69), .RST_VAL(RSTV)) dut (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_bus),
    .sda_pull(sda_pull), .regs_o(regs_o)
  );

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 190000", cyc);
      summary_and_end();
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic chk_bank(input string req);
    for (int i = 0; i < NREG; i++)
      chk(regs_o[i*8 +: 8] === exp_r[i], req, 64'(regs_o[i*8 +: 8]), 64'(exp_r[i]));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; scl = 1'b1; sda_host = 1'b1;
    wt(3);
    rst_n = 1'b1;
    wt(2);
    for (int i = 0; i < NREG; i++) exp_r[i] = RSTV;
    chk(sda_pull === 1'b0, "R1", 64'(sda_pull), 64'd0);
    chk_bank("R1");
  endtask

  task automatic bstart();
    sda_host = 1'b1; wt(Q);
    scl = 1'b1; wt(Q);
    sda_host = 1'b0; wt(Q);
    scl = 1'b0; wt(Q);
  endtask

  task automatic bstop();
    sda_host = 1'b0; wt(Q);
    scl = 1'b1; wt(Q);
    sda_host = 1'b1; wt(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_host = b[i]; wt(Q);
      scl = 1'b1; wt(Q);
      scl = 1'b0; wt(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_host = 1'b1; wt(Q);
    scl = 1'b1; wt(2);
    ack = (sda_bus == 1'b0);
    wt(Q - 2);
    scl = 1'b0; wt(Q);
  endtask

  function automatic bit data_ok(input bit live, input int m, input int n, input int k);
    return live && (k < n) && (m + k < NREG);
  endfunction

  task automatic frame(input logic [7:0] a, input logic [7:0] m, input logic [7:0] n,
                       input int nd, input bit fin_stop);
    bit ack, live, ok;
    logic [7:0] d;
    string tag;
    bstart();
    live = (a == 8'hD2);
    send_byte(a, ack);
    chk(ack == live, live ? "R2" : "R3", 64'(ack), 64'(live));
    send_byte(m, ack);
    chk(ack == live, live ? "R4" : "R3", 64'(ack), 64'(live));
    send_byte(n, ack);
    chk(ack == live, live ? "R4" : "R3", 64'(ack), 64'(live));
    for (int k = 0; k < nd; k++) begin
      d  = 8'($urandom);
      ok = data_ok(live, int'(m), int'(n), k);
      if (!live)       tag = "R3";
      else if (ok)     tag = "R5";
      else if (k >= int'(n)) tag = "R6";
      else             tag = "R7";
      if (ok) exp_r[int'(m) + k] = d;
      send_byte(d, ack);
      chk(ack == ok, tag, 64'(ack), 64'(ok));
      if (!ok) live = 1'b0;
    end
    if (fin_stop) begin
      bstop();
      chk_bank("R5");
    end
  endtask

  initial begin
    bit ack;
    void'($urandom(32'h00C0FFEE));
    do_reset();

    frame(8'hD2, 8'd2, 8'd3, 3, 1'b1);
    frame(8'hD2, 8'd0, 8'd2, 4, 1'b1);
    chk_bank("R6");
    frame(8'hD2, 8'd6, 8'd4, 4, 1'b1);
    chk_bank("R7");
    frame(8'hD4, 8'd0, 8'd3, 3, 1'b1);
    chk_bank("R3");
    frame(8'hD3, 8'd1, 8'd2, 2, 1'b1);
    chk_bank("R3");
    frame(8'hD2, 8'd3, 8'd0, 2, 1'b1);
    chk_bank("R6");

    frame(8'hD2, 8'd4, 8'd3, 1, 1'b0);
    send_bits(8'h3C, 4);
    bstop();
    chk_bank("R8");

    frame(8'hD2, 8'd0, 8'd4, 1, 1'b0);
    frame(8'hD2, 8'd5, 8'd1, 1, 1'b1);
    chk_bank("R8");
    chk(sda_pull === 1'b0, "R9", 64'(sda_pull), 64'd0);

    for (int t = 0; t < 40; t++) begin
      logic [7:0] a;
      int m, n, nd;
      a  = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'hD2;
      m  = $urandom_range(0, NREG + 1);
      n  = $urandom_range(0, NREG + 1);
      nd = $urandom_range(0, n + 2);
      frame(a, 8'(m), 8'(n), nd, 1'b1);
    end

    do_reset();
    frame(8'hD2, 8'd7, 8'd1, 1, 1'b1);
    summary_and_end();
  end
endmodule